// File: doc/BRIEF.md
# Soft-output serial check node processor

This block is a single serial check node processor for a layered LDPC decoder. It receives the soft-output values of the variable nodes on one check node, one value per clock. For each edge it removes that edge's earlier check-to-variable message to form a variable-to-check message. From those messages it builds new check-to-variable messages with normalized min-sum. It then returns the updated soft outputs in the order it received them.

Each check node (layer) keeps a compact record in a local store: the two smallest magnitudes, the edge position of the smallest, the overall sign parity and one sign bit per edge. On the next pass over the same layer, the old message for every edge is rebuilt from this record. The variable-to-check messages of a layer are held in one of two edge buffers. This lets the next layer be read while the previous one is still being written back, which is the pipelined overlap that roughly doubles throughput compared with waiting for each write-back.

Top module: `so_check_node_proc`

## Requirements
- R1: While reset is held, and after reset until the first layer closes, `out_valid_o` stays low.
- R2: When `in_iter0_i` is 1 at a layer's first read, the stored messages of that layer count as zero, so each variable-to-check message equals the incoming soft output after saturation.
- R3: The sign of the new check-to-variable message for an edge is the XOR of the sign bits of all the other variable-to-check messages of the layer. Sign bit 1 means negative; zero counts as positive.
- R4: The raw magnitude for an edge is the smallest magnitude among the other edges. It is tracked as smallest, second smallest and the position of the smallest. The earliest position wins the smallest slot, and on a tie the second smallest equals the smallest.
- R5: The raw magnitude m is scaled to floor(3*m/4) before the sign is applied.
- R6: Messages are 6-bit two's complement. The subtraction (soft output minus old message) and the addition (variable-to-check plus new message) both saturate symmetrically to the range -31..+31. An input of -32 is accepted.
- R7: In a layer of d edges whose last read is sampled at rising edge t, the output for edge j (j = 0..d-1) is registered at rising edge t+1+j. Outputs come one per cycle with no gaps, and exactly d outputs are produced.
- R8: When `in_iter0_i` is 0, the old message subtracted for edge j is rebuilt from the record that the previous pass of the same layer (`in_layer_i`) left behind. Records of different layers do not interact.
- R9: A new layer may start the cycle after the previous layer's last read. This includes the case where the previous layer's final output and the new layer's last read fall on the same rising edge, and both layers still produce correct results.
- R10: Cycles with `in_valid_i` low, inside a layer or between layers, have no effect on results. Only the position of the last read shifts the output timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Soft-output read valid |
| in_first_i | input | 1 | Marks the first read of a layer (with valid) |
| in_last_i | input | 1 | Marks the last read of a layer (with valid) |
| in_layer_i | input | LAY_W | Layer index, sampled with the first read |
| in_iter0_i | input | 1 | First-iteration flag, sampled with the first read |
| in_so_i | input | 6 | Incoming soft output, two's complement |
| out_valid_o | output | 1 | Updated soft output valid |
| out_so_o | output | 6 | Updated soft output, two's complement |

## Verification
The critical overlap is the rising edge where one layer's last read loads a new write-back context while the previous layer emits its final output from the old context. The same edge also writes the new layer's record. The bench provokes this by feeding two six-edge layers back to back. It judges the result by comparing every output of both layers against values computed from the requirements, and by checking the cycle each output appears. A shorter follow-on layer, padded with an idle cycle, then checks that the other edge buffer is reused without damaging either layer.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
  localparam int MSG_W   = 6;
  localparam int DC_MAX  = 16;
  localparam int MAG_W   = MSG_W - 1;
  localparam int IDX_W   = $clog2(DC_MAX);
  localparam int SAT_MAX = 2 ** (MSG_W - 1) - 1;

  typedef logic signed [MSG_W-1:0] msg_t;
  typedef logic [MAG_W-1:0]        mag_t;
  typedef logic [IDX_W-1:0]        idx_t;

  typedef struct packed {
    mag_t              min1;
    mag_t              min2;
    idx_t              idx;
    logic              tot;
    logic [DC_MAX-1:0] sgn;
  } rec_t;

  function automatic msg_t sat_add(msg_t a, msg_t b, logic sub);
    int s;
    s = sub ? int'(a) - int'(b) : int'(a) + int'(b);
    if (s > SAT_MAX) s = SAT_MAX;
    else if (s < -SAT_MAX) s = -SAT_MAX;
    return msg_t'(s);
  endfunction

  function automatic mag_t mag_of(msg_t v);
    int m;
    m = int'(v);
    if (m < 0) m = -m;
    if (m > SAT_MAX) m = SAT_MAX;
    return mag_t'(m);
  endfunction

  function automatic msg_t ctv_of(rec_t r, idx_t k);
    int n;
    mag_t m;
    m = (k == r.idx) ? r.min2 : r.min1;
    n = (3 * int'(m)) >>> 2;
    return (r.tot ^ r.sgn[k]) ? msg_t'(-n) : msg_t'(n);
  endfunction
endpackage

// File: rtl/cnp_layer_store.sv
module cnp_layer_store
  import cnp_pkg::*;
#(
  parameter int NUM_LAYERS = 8,
  localparam int LAY_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LAY_W-1:0] rd_sel_i,
  output rec_t             rd_rec_o,
  input  logic             wr_en_i,
  input  logic [LAY_W-1:0] wr_sel_i,
  input  rec_t             wr_rec_i
);
  rec_t mem_q [NUM_LAYERS];

  assign rd_rec_o = mem_q[rd_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LAYERS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_sel_i] <= wr_rec_i;
    end
  end
endmodule

// File: rtl/cnp_min_track.sv
module cnp_min_track
  import cnp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  idx_t k_i,
  input  msg_t vtc_i,
  output rec_t next_o
);
  rec_t acc_q, base;
  mag_t m;

  always_comb begin
    if (first_i) begin
      base      = '0;
      base.min1 = '1;
      base.min2 = '1;
    end else begin
      base = acc_q;
    end
    m      = mag_of(vtc_i);
    next_o = base;
    if (m < base.min1) begin
      next_o.min2 = base.min1;
      next_o.min1 = m;
      next_o.idx  = k_i;
    end else if (m < base.min2) begin
      next_o.min2 = m;
    end
    next_o.tot      = base.tot ^ vtc_i[MSG_W-1];
    next_o.sgn[k_i] = vtc_i[MSG_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (en_i) acc_q <= next_o;
  end
endmodule

// File: rtl/cnp_edge_buffer.sv
module cnp_edge_buffer
  import cnp_pkg::*;
#(
  parameter int NUM_CTX = 2
) (
  input  logic clk_i,
  input  logic wr_en_i,
  input  logic wr_ctx_i,
  input  idx_t wr_idx_i,
  input  msg_t wr_data_i,
  input  logic rd_ctx_i,
  input  idx_t rd_idx_i,
  output msg_t rd_data_o
);
  msg_t bank_rd [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    msg_t mem_q [DC_MAX];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_ctx_i == 1'(c))) mem_q[wr_idx_i] <= wr_data_i;
    end
    assign bank_rd[c] = mem_q[rd_idx_i];
  end

  assign rd_data_o = bank_rd[rd_ctx_i];
endmodule

// File: rtl/so_check_node_proc.sv
module so_check_node_proc
  import cnp_pkg::*;
#(
  parameter int NUM_LAYERS = 8,
  localparam int LAY_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [LAY_W-1:0] in_layer_i,
  input  logic             in_iter0_i,
  input  msg_t             in_so_i,
  output logic             out_valid_o,
  output msg_t             out_so_o
);
  idx_t             cnt_q, k;
  logic [LAY_W-1:0] lay_q, lay;
  logic             iter0_q, zero, rd_ctx_q, close;
  rec_t             rec_old, rec_new;
  msg_t             ctv_old, vtc;

  rec_t wb_rec_q;
  idx_t wb_cnt_q, wb_last_q;
  logic wb_ctx_q, wb_act_q;
  msg_t vtc_wb, so_new;

  assign k       = in_first_i ? '0 : cnt_q;
  assign lay     = in_first_i ? in_layer_i : lay_q;
  assign zero    = in_first_i ? in_iter0_i : iter0_q;
  assign close   = in_valid_i && in_last_i;
  assign ctv_old = zero ? '0 : ctv_of(rec_old, k);
  assign vtc     = sat_add(in_so_i, ctv_old, 1'b1);

  cnp_layer_store #(.NUM_LAYERS(NUM_LAYERS)) u_store (
    .clk_i, .rst_ni,
    .rd_sel_i(lay), .rd_rec_o(rec_old),
    .wr_en_i(close), .wr_sel_i(lay), .wr_rec_i(rec_new)
  );

  cnp_min_track u_track (
    .clk_i, .rst_ni,
    .en_i(in_valid_i), .first_i(in_first_i), .k_i(k), .vtc_i(vtc), .next_o(rec_new)
  );

  cnp_edge_buffer #(.NUM_CTX(2)) u_buf (
    .clk_i,
    .wr_en_i(in_valid_i), .wr_ctx_i(rd_ctx_q), .wr_idx_i(k), .wr_data_i(vtc),
    .rd_ctx_i(wb_ctx_q), .rd_idx_i(wb_cnt_q), .rd_data_o(vtc_wb)
  );

  // read side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      lay_q    <= '0;
      iter0_q  <= 1'b0;
      rd_ctx_q <= 1'b0;
    end else if (in_valid_i) begin
      cnt_q <= idx_t'(k + 1'b1);
      if (in_first_i) begin
        lay_q   <= in_layer_i;
        iter0_q <= in_iter0_i;
      end
      if (in_last_i) rd_ctx_q <= ~rd_ctx_q;
    end
  end

  // write-back side; a closing layer overrides the context as its last item leaves
  assign so_new = sat_add(vtc_wb, ctv_of(wb_rec_q, wb_cnt_q), 1'b0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_rec_q  <= '0;
      wb_cnt_q  <= '0;
      wb_last_q <= '0;
      wb_ctx_q  <= 1'b0;
      wb_act_q  <= 1'b0;
    end else if (close) begin
      wb_rec_q  <= rec_new;
      wb_cnt_q  <= '0;
      wb_last_q <= k;
      wb_ctx_q  <= rd_ctx_q;
      wb_act_q  <= 1'b1;
    end else if (wb_act_q) begin
      wb_cnt_q <= idx_t'(wb_cnt_q + 1'b1);
      if (wb_cnt_q == wb_last_q) wb_act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_so_o    <= '0;
    end else begin
      out_valid_o <= wb_act_q;
      if (wb_act_q) out_so_o <= so_new;
    end
  end
endmodule

// File: rtl/cnp_checker.sv
module cnp_checker
  import cnp_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_first_i,
  input logic in_last_i,
  input logic out_valid_o,
  input msg_t out_so_o
);
  logic [7:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= pend_q + {7'b0, in_valid_i} - {7'b0, out_valid_o};
  end

  AST_FIRST_IS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_first_i |-> in_valid_i); // R10

  AST_WB_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && in_last_i, 2) |-> out_valid_o); // R7

  AST_NO_ORPHAN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (pend_q != 8'd0)); // R7

  AST_SYM_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_so_o != msg_t'(-SAT_MAX - 1))); // R6
endmodule

bind so_check_node_proc cnp_checker u_chk (.*);

// File: tb/so_check_node_proc_bench.sv
`timescale 1ns/1ps
module so_check_node_proc_bench;
  import cnp_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_iter0 = 1'b0;
  logic [2:0] in_layer = '0;
  msg_t       in_so = '0;
  logic       out_valid;
  msg_t       out_so;

  always #2.5 clk = ~clk;

  so_check_node_proc u_so_check_node_proc (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_first_i(in_first), .in_last_i(in_last),
    .in_layer_i(in_layer), .in_iter0_i(in_iter0), .in_so_i(in_so),
    .out_valid_o(out_valid), .out_so_o(out_so)
  );

  int    cyc = 0;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  int    exp_so_q[$];
  int    exp_cyc_q[$];
  string exp_tag_q[$];

  int m_min1[8], m_min2[8], m_idx[8];
  bit m_tot[8];
  bit m_sgn[8][16];
  int so_v[16];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clip(int v);
    if (v > 31) return 31;
    if (v < -31) return -31;
    return v;
  endfunction

  function automatic int scale(int m);
    return (3 * m) / 4;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_layer(int layer, bit iter0, int d, int gap_mask, string tag);
    int vtc[16];
    int mn1, mn2, ix, old, a, n;
    bit tot, s;
    mn1 = 31; mn2 = 31; ix = 0; tot = 1'b0;
    for (int k = 0; k < d; k++) begin
      old = 0;
      if (!iter0) begin
        n   = scale((k == m_idx[layer]) ? m_min2[layer] : m_min1[layer]);
        old = (m_tot[layer] ^ m_sgn[layer][k]) ? -n : n;
      end
      vtc[k] = clip(so_v[k] - old);
      a = (vtc[k] < 0) ? -vtc[k] : vtc[k];
      if (a < mn1) begin mn2 = mn1; mn1 = a; ix = k; end
      else if (a < mn2) mn2 = a;
      tot ^= (vtc[k] < 0);
    end
    m_min1[layer] = mn1; m_min2[layer] = mn2; m_idx[layer] = ix; m_tot[layer] = tot;
    for (int k = 0; k < 16; k++) m_sgn[layer][k] = (k < d) ? (vtc[k] < 0) : 1'b0;
    for (int k = 0; k < d; k++) begin
      n = scale((k == ix) ? mn2 : mn1);
      s = tot ^ (vtc[k] < 0);
      exp_so_q.push_back(clip(vtc[k] + (s ? -n : n)));
      exp_tag_q.push_back(tag);
    end
    for (int k = 0; k < d; k++) begin
      if ((gap_mask >> k) & 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (k == 0);
      in_last  = (k == d - 1);
      in_layer = 3'(layer);
      in_iter0 = iter0;
      in_so    = msg_t'(so_v[k]);
      if (k == d - 1)
        for (int j = 0; j < d; j++) exp_cyc_q.push_back(cyc + 2 + j);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic load4(int a, int b, int c, int e);
    so_v[0] = a; so_v[1] = b; so_v[2] = c; so_v[3] = e;
  endtask

  // monitor: value and timing of every write-back
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_so_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected output %0d expected none", out_so);
      end else begin
        check(exp_tag_q.pop_front(), int'(out_so), exp_so_q.pop_front());
        check("R7 timing", cyc, exp_cyc_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R7: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 after reset", int'(out_valid), 0);

    load4(3, -5, 7, 2);
    run_layer(0, 1'b1, 4, 0, "R2");
    idle(6);

    so_v[0] = -9; so_v[1] = 12;
    run_layer(6, 1'b1, 2, 0, "R3");
    idle(4);

    so_v[0] = 5; so_v[1] = 3; so_v[2] = -3; so_v[3] = 7; so_v[4] = 3; so_v[5] = -20;
    run_layer(1, 1'b1, 6, 0, "R4");
    idle(8);

    so_v[0] = 0; so_v[1] = -17; so_v[2] = 28;
    run_layer(5, 1'b1, 3, 0, "R5");
    idle(5);

    load4(31, 30, -32, -29); so_v[4] = 31;
    run_layer(2, 1'b1, 5, 0, "R6");
    idle(7);

    for (int k = 0; k < 16; k++) so_v[k] = ((k * 11) % 41) - 20;
    run_layer(3, 1'b1, 16, 0, "R7");
    idle(20);

    // second pass, back to back
    load4(-4, 9, 1, -2);
    run_layer(0, 1'b0, 4, 0, "R8");
    so_v[0] = 10; so_v[1] = -1; so_v[2] = 6; so_v[3] = 14; so_v[4] = -8; so_v[5] = 2;
    run_layer(1, 1'b0, 6, 0, "R8");
    so_v[0] = -6; so_v[1] = 4; so_v[2] = 13; so_v[3] = -25; so_v[4] = 1; so_v[5] = 9;
    run_layer(4, 1'b1, 6, 0, "R9");
    load4(-30, 25, 31, -31); so_v[4] = 2;
    run_layer(2, 1'b0, 5, 32'h4, "R10");
    idle(4);

    so_v[0] = 11; so_v[1] = -26; so_v[2] = 5;
    run_layer(5, 1'b0, 3, 32'h5, "R10");
    idle(20);

    check("R7 all outputs seen", exp_so_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule